// File: doc/BRIEF.md
# Colour Look-up Table Register Port

This block holds a colour look-up table and the host-side register port used to fill it and read it back. Each table entry stores an 8-bit red, green and blue value. There are 256 ordinary entries and a small bank of 4 overlay entries, 260 entries in all. The host uses 32-bit register accesses, and each colour byte travels in the top byte of the data word. The host first writes an entry number to the index register. It then moves one entry through three successive accesses to a data offset, red first, then green, then blue. After the blue access the entry number steps forward by one and wraps within 256. One data offset selects the ordinary entries. A second data offset selects overlay entry 256 + (index & 3).

The display path has its own lookup port, separate from the host port. It presents any entry number from 0 to 259 and receives that entry's packed RGB value one clock later. Writes to the remaining offsets in the register window are control-register accesses. The block accepts them and they have no effect.

Top module: `clut_regif`

## Requirements
- R1: After reset every component of every entry is 0, except entries 255, 256 and 258, which read as 8'hFF in all three components.
- R2: A host write to byte offset 0 loads the entry index from data bits 31:24 and sets the component sequencer to red.
- R3: Host writes to offset 4 store data bits 31:24 into the ordinary entry at the current index. The first write stores red, the second green and the third blue. After the blue write the sequencer returns to red and the index increments modulo 256, so 255 wraps to 0.
- R4: Host writes to offset 12 store components into overlay entry 256 + (index & 3). They use the same red, green, blue sequence and the same index increment as R3.
- R5: A host read of offset 4 (ordinary) or offset 12 (overlay) returns the component the sequencer selects. The component is in bits 31:24 and bits 23:0 are 0. hostRdValid rises and the data is present one cycle after hostRdEn. Reads advance the sequencer and the index exactly as writes do.
- R6: A host write to any offset other than 0, 4 and 12 changes no entry, no index and no sequencer state.
- R7: A host read of any offset other than 4 and 12 returns 0 and leaves the index and the sequencer unchanged.
- R8: dispRgb is {red, green, blue} of entry dispIdx one cycle after dispIdx is presented, with red in bits 23:16 and blue in bits 7:0. Indices 260 and above return 0.
- R9: When a host write and a display lookup hit the same entry in the same cycle, the display port returns the entry's value from before the write.
- R10: When hostWrEn and hostRdEn are both high in one cycle, only the write takes effect. The read returns 0 with hostRdValid high and does not advance the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe, one access per cycle |
| hostRdEn | input | 1 | Host read strobe, one access per cycle |
| hostAddr | input | ADDR_W | Byte offset inside the register window |
| hostWrData | input | 32 | Host write data; the component byte is in bits 31:24 |
| hostRdValid | output | 1 | Read data valid, one cycle after hostRdEn |
| hostRdData | output | 32 | Read data; the component is in bits 31:24 |
| dispIdx | input | 9 | Display lookup entry number |
| dispRgb | output | 24 | Looked-up {red, green, blue}, one cycle later |

## Verification
Every result of this block appears exactly one clock after its stimulus. Host read data and hostRdValid become valid one cycle after hostRdEn. dispRgb follows dispIdx by one cycle. A write becomes visible to both ports from the cycle after the write. The bench drives inputs just after a rising edge and pushes the expected value into a queue at the same moment. A monitor pops that queue at the falling edge that follows the next rising edge, so each comparison lands in exactly the cycle the result is due. For a same-cycle write and lookup, the expected display value is taken from the model before the write is applied.

// File: rtl/clut_pkg.sv
package clut_pkg;
  parameter int NORMAL_N  = 256;
  parameter int OVERLAY_N = 4;
  localparam int TOTAL_N  = NORMAL_N + OVERLAY_N;
  localparam int SEL_W    = $clog2(TOTAL_N);
  localparam int IDX_W    = $clog2(NORMAL_N);
  localparam int OVL_W    = $clog2(OVERLAY_N);
  localparam int COMP_W   = 8;
  localparam int RGB_W    = 3 * COMP_W;

  // byte offsets inside the register window
  localparam int OFF_INDEX   = 0;
  localparam int OFF_NORMAL  = 4;
  localparam int OFF_OVERLAY = 12;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrComp;
    logic             rdComp;
    logic [SEL_W-1:0] entry;
    comp_e            comp;
  } strobe_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        topByte,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  curIdx,
  output comp_e             curSeq,
  output logic              rdValid
);
  logic isIndex, isNormal, isOverlay, isData, stepSeq;
  logic [SEL_W-1:0] entrySel;

  assign isIndex   = (addr == ADDR_W'(OFF_INDEX));
  assign isNormal  = (addr == ADDR_W'(OFF_NORMAL));
  assign isOverlay = (addr == ADDR_W'(OFF_OVERLAY));
  assign isData    = isNormal | isOverlay;

  always_comb begin
    if (isOverlay) entrySel = SEL_W'(NORMAL_N) + SEL_W'(curIdx[OVL_W-1:0]);
    else           entrySel = SEL_W'(curIdx);
  end

  // a write always wins; a read in the same cycle is dropped
  assign stepSeq = isData & (wrEn | rdEn);

  always_comb begin
    strb.wrComp = wrEn & isData;
    strb.rdComp = rdEn & ~wrEn & isData;
    strb.entry  = entrySel;
    strb.comp   = curSeq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= '0;
      curSeq  <= COMP_RED;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (wrEn && isIndex) begin
        curIdx <= topByte[IDX_W-1:0];
        curSeq <= COMP_RED;
      end else if (stepSeq) begin
        unique case (curSeq)
          COMP_RED: curSeq <= COMP_GRN;
          COMP_GRN: curSeq <= COMP_BLU;
          default: begin
            curSeq <= COMP_RED;
            curIdx <= curIdx + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [7:0]       wrByte,
  input  logic [SEL_W-1:0] dispIdx,
  output logic [31:0]      rdData,
  output logic [RGB_W-1:0] dispRgb
);
  logic [RGB_W-1:0] table_q [TOTAL_N];
  logic [RGB_W-1:0] hostEntry;
  logic [7:0]       hostByte;

  function automatic logic startsWhite(int e);
    return (e == NORMAL_N - 1) || (e == NORMAL_N) || (e == NORMAL_N + 2);
  endfunction

  assign hostEntry = table_q[strb.entry];

  always_comb begin
    unique case (strb.comp)
      COMP_RED: hostByte = hostEntry[23:16];
      COMP_GRN: hostByte = hostEntry[15:8];
      default:  hostByte = hostEntry[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < TOTAL_N; e++)
        table_q[e] <= startsWhite(e) ? {RGB_W{1'b1}} : '0;
    end else if (strb.wrComp) begin
      unique case (strb.comp)
        COMP_RED: table_q[strb.entry][23:16] <= wrByte;
        COMP_GRN: table_q[strb.entry][15:8]  <= wrByte;
        default:  table_q[strb.entry][7:0]   <= wrByte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      dispRgb <= '0;
    end else begin
      rdData  <= strb.rdComp ? {hostByte, 24'h0} : 32'h0;
      dispRgb <= (dispIdx < SEL_W'(TOTAL_N)) ? table_q[dispIdx] : '0;
    end
  end
endmodule

// File: rtl/clut_regif.sv
module clut_regif
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic              hostRdValid,
  output logic [31:0]       hostRdData,
  input  logic [SEL_W-1:0]  dispIdx,
  output logic [RGB_W-1:0]  dispRgb
);
  strobe_t          strb;
  logic [IDX_W-1:0] curIdx;
  comp_e            curSeq;

  clut_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(hostWrEn), .rdEn(hostRdEn),
    .addr(hostAddr), .topByte(hostWrData[31:24]), .strb(strb),
    .curIdx(curIdx), .curSeq(curSeq), .rdValid(hostRdValid)
  );

  clut_store store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(hostWrData[31:24]),
    .dispIdx(dispIdx), .rdData(hostRdData), .dispRgb(dispRgb)
  );
endmodule

// File: rtl/clut_regif_chk.sv
module clut_regif_chk
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [31:0]       hostWrData,
  input logic              hostRdValid,
  input logic [31:0]       hostRdData,
  input logic [IDX_W-1:0]  curIdx,
  input comp_e             curSeq
);
  logic known;
  assign known = (hostAddr == ADDR_W'(OFF_INDEX)) || (hostAddr == ADDR_W'(OFF_NORMAL)) ||
                 (hostAddr == ADDR_W'(OFF_OVERLAY));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_W'(OFF_INDEX)) |=>
      (curSeq == COMP_RED && curIdx == $past(hostWrData[31:24])));

  assert_blue_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_W'(OFF_NORMAL) && curSeq == COMP_BLU) |=>
      (curSeq == COMP_RED && curIdx == $past(curIdx) + 8'd1));

  assert_seq_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    curSeq != 2'd3);

  assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !known) |=> ($stable(curIdx) && $stable(curSeq)));

  assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn |=> hostRdValid);

  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> (hostRdData[23:0] == 24'h0));

  assert_other_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && hostAddr != ADDR_W'(OFF_NORMAL) &&
     hostAddr != ADDR_W'(OFF_OVERLAY)) |=>
      (hostRdData == 32'h0 && $stable(curIdx) && $stable(curSeq)));
endmodule

bind clut_regif clut_regif_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdValid(hostRdValid),
  .hostRdData(hostRdData), .curIdx(curIdx), .curSeq(curSeq)
);

// File: tb/tb_clut_regif.sv
module tb_clut_regif;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic        hostRdValid;
  logic [31:0] hostRdData;
  logic [8:0]  dispIdx = '0;
  logic [23:0] dispRgb;

  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  clut_regif dut (.*);

  // reference model, built from the requirements
  logic [23:0] mdl [0:259];
  int mIdx, mSeq;

  logic [31:0] rdQ[$];   string rdTagQ[$];
  logic [23:0] dpQ[$];   string dpTagQ[$];
  logic dispReq = 1'b0, dispArm = 1'b0;

  always @(posedge clk) dispArm <= dispReq;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (rdQ.size() == 0) check(1, 0, "R5 unexpected read valid");
      else check(hostRdData, rdQ.pop_front(), rdTagQ.pop_front());
    end
    if (rstN && dispArm && dpQ.size() > 0)
      check({8'h0, dispRgb}, {8'h0, dpQ.pop_front()}, dpTagQ.pop_front());
  end

  function automatic logic [7:0] mGet(int e, int c);
    return mdl[e][23 - 8*c -: 8];
  endfunction

  function automatic int mEntry(int a);
    return (a == 12) ? 256 + (mIdx & 3) : mIdx;
  endfunction

  // one cycle of stimulus
  task automatic drive(input logic wr, input logic rd, input int a, input logic [7:0] b,
                       input logic dq, input int di, input string tag);
    @(posedge clk); #1;
    hostWrEn = wr; hostRdEn = rd; hostAddr = 4'(a);
    hostWrData = {b, 24'h00_1234}; dispReq = dq; dispIdx = 9'(di);
    if (dq) begin
      dpQ.push_back(di < 260 ? mdl[di] : 24'h0); dpTagQ.push_back(tag);
    end
    if (rd) begin
      if (!wr && (a == 4 || a == 12)) rdQ.push_back({mGet(mEntry(a), mSeq), 24'h0});
      else rdQ.push_back(32'h0);
      rdTagQ.push_back(tag);
    end
    if (wr && a == 0) begin
      mIdx = b; mSeq = 0;
    end else if ((wr || rd) && (a == 4 || a == 12)) begin
      if (wr) mdl[mEntry(a)][23 - 8*mSeq -: 8] = b;
      if (mSeq == 2) begin mSeq = 0; mIdx = (mIdx + 1) % 256; end
      else mSeq++;
    end
    @(posedge clk); #1;
    hostWrEn = 0; hostRdEn = 0; dispReq = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] b);
    drive(1, 0, a, b, 0, 0, "");
  endtask
  task automatic rd(input int a, input string tag);
    drive(0, 1, a, 8'h0, 0, 0, tag);
  endtask
  task automatic look(input int di, input string tag);
    drive(0, 0, 1, 8'h0, 1, di, tag);
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int e = 0; e < 260; e++)
      mdl[e] = (e == 255 || e == 256 || e == 258) ? 24'hFFFFFF : 24'h0;
    mIdx = 0; mSeq = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(hostRdData, 0, "R1 reset read data");
    check({31'h0, hostRdValid}, 0, "R1 reset read valid");

    // R1 / R8: reset contents through the display port
    look(0,   "R1 entry 0");
    look(254, "R1 entry 254");
    look(255, "R1 entry 255");
    look(256, "R1 entry 256");
    look(257, "R1 entry 257");
    look(258, "R1 entry 258");
    look(259, "R1 entry 259");
    look(300, "R8 out-of-range index");

    // R5: host readback of a white entry, index then wraps
    wr(0, 8'd255);
    rd(4, "R5 read red 255"); rd(4, "R5 read green 255"); rd(4, "R5 read blue 255");
    rd(4, "R5 read after wrap entry 0 red");

    // R3: ordinary entry write and readback
    wr(0, 8'd10);
    wr(4, 8'h11); wr(4, 8'h22); wr(4, 8'h33);
    wr(4, 8'h44);
    look(10, "R3 entry 10"); look(11, "R3 next entry red");
    wr(0, 8'd10);
    rd(4, "R3 readback red"); rd(4, "R3 readback green"); rd(4, "R3 readback blue");

    // R3: wrap from 255 to 0
    wr(0, 8'd255);
    wr(4, 8'hA1); wr(4, 8'hA2); wr(4, 8'hA3);
    wr(4, 8'h5A);
    look(255, "R3 entry 255 written"); look(0, "R3 wrap to entry 0");

    // R4: overlay bank, index 6 -> entry 258
    wr(0, 8'd6);
    wr(12, 8'h01); wr(12, 8'h02); wr(12, 8'h03);
    look(258, "R4 overlay entry 258"); look(6, "R4 ordinary entry 6 untouched");
    wr(0, 8'd6);
    rd(12, "R4 overlay read red"); rd(12, "R4 overlay read green");
    rd(12, "R4 overlay read blue");
    rd(12, "R4 overlay next index 7 -> entry 259");

    // R6: control write in the middle of a sequence
    wr(0, 8'd20);
    wr(4, 8'h61); wr(8, 8'hEE); wr(2, 8'hEE);
    wr(4, 8'h62); wr(4, 8'h63);
    look(20, "R6 entry 20 after control writes");
    rd(4, "R6 index advanced to 21");

    // R7: unsupported reads
    wr(0, 8'd20);
    rd(8, "R7 read offset 8"); rd(0, "R7 read offset 0");
    rd(4, "R7 sequencer unchanged red");

    // R2: index write restarts at red
    wr(0, 8'd50);
    wr(4, 8'h01); wr(4, 8'h02);
    wr(0, 8'd50);
    wr(4, 8'h07);
    look(50, "R2 sequencer back to red");

    // R9: same-cycle write and lookup of one entry
    wr(0, 8'd40);
    wr(4, 8'h91); wr(4, 8'h92);
    drive(1, 0, 4, 8'h93, 1, 40, "R9 old value during write");
    look(40, "R9 new value next cycle");

    // R10: write and read together
    wr(0, 8'd70);
    drive(1, 1, 4, 8'hC1, 0, 0, "R10 read dropped");
    rd(4, "R10 sequencer at green");
    look(70, "R10 write took effect");

    repeat (4) @(posedge clk);
    check(rdQ.size() + dpQ.size(), 0, "R5 pending results");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule